// File: doc/BRIEF.md
# Multiply, Divide and Accumulate Unit

A byte-addressed arithmetic engine holding two 16-bit operand registers and a 40-bit result register. Software loads operands one byte at a time through a write port, picks one of three operations through a small mode register, and reads the result back one byte at a time. The operations are a signed 16x16 multiply, a division of a signed dividend by an unsigned divisor, and a signed multiply-accumulate into the 40-bit result.

Writing the high byte of operand B is the trigger. Multiply and accumulate complete on that same clock edge. Division runs an iterative restoring divider for 16 cycles. `busy` is high during those cycles, and the unit ignores every write while `busy` is high. The accumulator wraps modulo 2^40. Any wrap, upward or downward, sets a sticky overflow flag.

Top module: `mdac_unit`

## Requirements
- R1: After reset the result is zero, the status byte reads 0x00 and `busy` is low. Operands A and B are zero and the mode is multiply.
- R2: Write selects: 0 is mode (bit 1 selects accumulate, bit 0 selects divide, accumulate takes priority), 1 and 2 are A low and high, 3 and 4 are B low and high. Read selects 0 to 4 return result bytes from least to most significant. Select 5 returns status with overflow at bit 7 and zero elsewhere. Other read selects return 0x00.
- R3: In multiply mode, a write to B high stores the signed product of A and B, sign-extended to 40 bits. The result is visible after that same edge and `busy` stays low.
- R4: After a multiply, B reads as zero and A keeps its value, so a later write to B high alone uses B = {new byte, 0x00}.
- R5: In divide mode, A is signed and B is unsigned. The quotient truncates toward zero and the remainder takes the dividend's sign. The remainder's 16-bit pattern goes to result bits 31:16, the quotient to bits 15:0, and bits 39:32 are zero.
- R6: A divide holds `busy` high for exactly 16 cycles after the trigger edge, and the result updates as `busy` falls. A and B are both cleared by the trigger.
- R7: Dividing by zero still takes 16 cycles and leaves a result of zero.
- R8: While `busy` is high, writes to the mode and operand registers have no effect.
- R9: A mode write with bit 1 set clears the result and the overflow flag. A mode write with bit 1 clear leaves the result unchanged.
- R10: In accumulate mode, a write to B high adds the signed product to the result. B is then cleared and A is kept.
- R11: An accumulate whose true sum is at least 2^40 or below zero stores the sum modulo 2^40 and sets the overflow flag. The flag stays set through later operations until reset or an R9 clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_sel | input | 4 | Write register select |
| wr_data | input | 8 | Write byte |
| rd_sel | input | 4 | Read register select |
| rd_data | output | 8 | Read byte (combinational from select) |
| busy | output | 1 | Divide in progress; writes ignored |

## Verification
The assertions assume that software does not need its writes to take effect while `busy` is high. They also assume that the accumulator's wrap and flag follow the signed product added to the unsigned 40-bit result. The directed stimulus holds `wr_en` for one cycle per write and waits for `busy` to fall before judging a divide. It deliberately writes during `busy` only in the scenario that checks those writes are dropped. Operand values are chosen to reach both edges of the signed range and the top of the unsigned divisor range.

// File: rtl/mdac_pkg.sv
package mdac_pkg;

    localparam int unsigned OP_W   = 16;
    localparam int unsigned RES_W  = 40;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEL_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_MODE = 4'd0,
        SEL_A_LO = 4'd1,
        SEL_A_HI = 4'd2,
        SEL_B_LO = 4'd3,
        SEL_B_HI = 4'd4
    } wsel_e;

    typedef struct packed {
        logic acc;
        logic div;
    } mode_t;

    typedef enum logic [1:0] {
        OP_MUL = 2'd0,
        OP_DIV = 2'd1,
        OP_ACC = 2'd2
    } op_e;

    function automatic op_e decode_op(input mode_t m);
        if (m.acc)      return OP_ACC;
        else if (m.div) return OP_DIV;
        else            return OP_MUL;
    endfunction

endpackage

// File: rtl/mdac_divider.sv
module mdac_divider #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          run_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvs_q;
    logic          neg_q;
    logic          dz_q;

    logic [W:0]    trial;
    logic          fits;
    logic [W:0]    trial_sub;
    logic [W-1:0]  rem_nx;
    logic [W-1:0]  quo_nx;

    // one restoring step: shift in next dividend bit, subtract if it fits
    always_comb begin
        trial     = {rem_q, quo_q[W-1]};
        fits      = (trial >= {1'b0, dvs_q});
        trial_sub = trial - {1'b0, dvs_q};
        rem_nx    = fits ? trial_sub[W-1:0] : trial[W-1:0];
        quo_nx    = {quo_q[W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            neg_q <= 1'b0;
            dz_q  <= 1'b0;
        end else if (start && !run_q) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            rem_q <= '0;
            quo_q <= dividend[W-1] ? (~dividend + 1'b1) : dividend;
            dvs_q <= divisor;
            neg_q <= dividend[W-1];
            dz_q  <= (divisor == '0);
        end else if (run_q) begin
            rem_q <= rem_nx;
            quo_q <= quo_nx;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) run_q <= 1'b0;
        end
    end

    assign busy = run_q;
    assign done = run_q && (cnt_q == LAST);

    // sign restore: quotient toward zero, remainder follows the dividend
    always_comb begin
        if (dz_q) begin
            quotient  = '0;
            remainder = '0;
        end else if (neg_q) begin
            quotient  = ~quo_nx + 1'b1;
            remainder = ~rem_nx + 1'b1;
        end else begin
            quotient  = quo_nx;
            remainder = rem_nx;
        end
    end

    // R5: partial remainder never reaches the divisor
    a_r5_rem_bound: assert property (@(posedge clk) disable iff (rst)
        (run_q && dvs_q != '0) |-> (rem_q < dvs_q));

    // R6: every run starts from step zero
    a_r6_run_starts_clean: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> (cnt_q == '0));

    // R6: the finishing step ends the run
    a_r6_done_ends_run: assert property (@(posedge clk) disable iff (rst)
        done |=> !run_q);

endmodule

// File: rtl/mdac_mac.sv
module mdac_mac #(
    parameter int unsigned OP_W  = 16,
    parameter int unsigned RES_W = 40
) (
    input  logic [OP_W-1:0]  a,
    input  logic [OP_W-1:0]  b,
    input  logic [RES_W-1:0] acc_in,
    output logic [RES_W-1:0] prod_ext,
    output logic [RES_W-1:0] sum,
    output logic             wrap
);
    localparam int unsigned PW  = 2 * OP_W;
    localparam int unsigned EXT = RES_W - PW;

    logic signed [PW-1:0] prod;
    logic [RES_W:0]       sum_w;

    assign prod     = $signed(a) * $signed(b);
    assign prod_ext = {{EXT{prod[PW-1]}}, prod};

    // extra top bit catches both carry out and borrow
    assign sum_w = {1'b0, acc_in} + {prod_ext[RES_W-1], prod_ext};
    assign sum   = sum_w[RES_W-1:0];
    assign wrap  = sum_w[RES_W];

endmodule

// File: rtl/mdac_rdmux.sv
module mdac_rdmux #(
    parameter int unsigned RES_W  = 40,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned SEL_W  = 4
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [RES_W-1:0]  res,
    input  logic              ovf,
    output logic [BYTE_W-1:0] data
);
    localparam int unsigned NB = RES_W / BYTE_W;

    always_comb begin
        data = '0;
        for (int i = 0; i < NB; i++) begin
            if (sel == SEL_W'(i)) data = res[i*BYTE_W +: BYTE_W];
        end
        if (sel == SEL_W'(NB)) data = {ovf, {(BYTE_W-1){1'b0}}};
    end

endmodule

// File: rtl/mdac_unit.sv
module mdac_unit
    import mdac_pkg::*;
#(
    parameter int unsigned OPW  = OP_W,
    parameter int unsigned RESW = RES_W,
    parameter int unsigned BW   = BYTE_W,
    parameter int unsigned SW   = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [BW-1:0] wr_data,
    input  logic [SW-1:0] rd_sel,
    output logic [BW-1:0] rd_data,
    output logic          busy
);
    localparam int unsigned PADW = RESW - 2 * OPW;

    mode_t           mode_q;
    logic [OPW-1:0]  op_a_q;
    logic [OPW-1:0]  op_b_q;
    logic [RESW-1:0] res_q;
    logic            ovf_q;

    op_e             op;
    logic            wr_ok;
    logic            trig;
    logic [OPW-1:0]  b_next;

    logic [RESW-1:0] prod_ext;
    logic [RESW-1:0] acc_sum;
    logic            acc_wrap;

    logic            div_busy;
    logic            div_done;
    logic [OPW-1:0]  div_quo;
    logic [OPW-1:0]  div_rem;
    logic            div_start;

    assign op        = decode_op(mode_q);
    assign wr_ok     = wr_en && !div_busy;
    assign trig      = wr_ok && (wr_sel == SEL_B_HI);
    assign b_next    = {wr_data, op_b_q[BW-1:0]};
    assign div_start = trig && (op == OP_DIV);
    assign busy      = div_busy;

    mdac_mac #(.OP_W(OPW), .RES_W(RESW)) mac_i (
        .a        (op_a_q),
        .b        (b_next),
        .acc_in   (res_q),
        .prod_ext (prod_ext),
        .sum      (acc_sum),
        .wrap     (acc_wrap)
    );

    mdac_divider #(.W(OPW)) div_i (
        .clk       (clk),
        .rst       (rst),
        .start     (div_start),
        .dividend  (op_a_q),
        .divisor   (b_next),
        .busy      (div_busy),
        .done      (div_done),
        .quotient  (div_quo),
        .remainder (div_rem)
    );

    mdac_rdmux #(.RES_W(RESW), .BYTE_W(BW), .SEL_W(SW)) rd_i (
        .sel  (rd_sel),
        .res  (res_q),
        .ovf  (ovf_q),
        .data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            op_a_q <= '0;
            op_b_q <= '0;
            res_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (div_done) res_q <= {{PADW{1'b0}}, div_rem, div_quo};
            if (wr_ok) begin
                case (wr_sel)
                    SEL_MODE: begin
                        mode_q <= mode_t'(wr_data[1:0]);
                        if (wr_data[1]) begin
                            res_q <= '0;
                            ovf_q <= 1'b0;
                        end
                    end
                    SEL_A_LO: op_a_q[BW-1:0]   <= wr_data;
                    SEL_A_HI: op_a_q[OPW-1:BW] <= wr_data;
                    SEL_B_LO: op_b_q[BW-1:0]   <= wr_data;
                    SEL_B_HI: begin
                        case (op)
                            OP_MUL: begin
                                res_q  <= prod_ext;
                                op_b_q <= '0;
                            end
                            OP_ACC: begin
                                res_q  <= acc_sum;
                                ovf_q  <= ovf_q | acc_wrap;
                                op_b_q <= '0;
                            end
                            OP_DIV: begin
                                op_a_q <= '0;
                                op_b_q <= '0;
                            end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: writes during a divide leave mode and operands alone
    a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> ($stable(op_a_q) && $stable(op_b_q) && $stable(mode_q)));

    // R3: multiply finishes at the trigger edge
    a_r3_mul_no_busy: assert property (@(posedge clk) disable iff (rst)
        (trig && op == OP_MUL) |=> !busy);

    // R4: multiply clears B and keeps A
    a_r4_mul_operands: assert property (@(posedge clk) disable iff (rst)
        (trig && op == OP_MUL) |=> (op_b_q == '0 && op_a_q == $past(op_a_q)));

    // R6: divide trigger raises busy and clears both operands
    a_r6_div_launch: assert property (@(posedge clk) disable iff (rst)
        (trig && op == OP_DIV) |=> (busy && op_a_q == '0 && op_b_q == '0));

    // R5: divide result leaves the top byte clear
    a_r5_div_top_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (res_q[RESW-1:2*OPW] == '0));

    // R11: overflow holds until an explicit clear
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !(wr_ok && wr_sel == SEL_MODE && wr_data[1])) |=> ovf_q);

endmodule

// File: tb/mdac_unit_tb.sv
`timescale 1ns/1ps
module mdac_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [3:0] wr_sel;
    logic [7:0] wr_data;
    logic [3:0] rd_sel;
    logic [7:0] rd_data;
    logic       busy;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mdac_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [7:0] d);
        rd_sel = s;
        #1;
        d = rd_data;
    endtask

    task automatic rd_res(output logic [39:0] r);
        logic [7:0] b;
        r = '0;
        for (int i = 0; i < 5; i++) begin
            rd(4'(i), b);
            r[i*8 +: 8] = b;
        end
    endtask

    function automatic logic [39:0] mul_exp(input int a, input int b);
        longint p;
        p = longint'(a) * longint'(b);
        return p[39:0];
    endfunction

    function automatic logic [39:0] div_exp(input int a, input int b);
        int q;
        int r;
        if (b == 0) return '0;
        q = a / b;
        r = a % b;
        return {8'h00, r[15:0], q[15:0]};
    endfunction

    task automatic load_ab(input int a, input int b);
        wr(4'd1, a[7:0]); wr(4'd2, a[15:8]);
        wr(4'd3, b[7:0]); wr(4'd4, b[15:8]);
    endtask

    task automatic wait_div(output int n);
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [39:0] r;
        logic [7:0]  s;
        rd_res(r);
        check("R1 result after reset", r, 0);
        rd(4'd5, s);
        check("R1 status after reset", s, 0);
        check("R1 busy after reset", busy, 0);
        rd(4'd9, s);
        check("R2 unused read select", s, 0);
        wr(4'd4, 8'h05);
        rd_res(r);
        check("R1 operand A zero after reset", r, 0);
    endtask

    task automatic t_mul;
        logic [39:0] r;
        logic [7:0]  s;
        wr(4'd0, 8'h00);
        load_ab(-300, 1234);
        check("R3 busy low after multiply", busy, 0);
        rd_res(r);
        check("R3 negative product", r, mul_exp(-300, 1234));
        wr(4'd4, 8'h02);
        rd_res(r);
        check("R4 A kept, B cleared", r, mul_exp(-300, 512));
        load_ab(-32768, -32768);
        rd_res(r);
        check("R3 extreme product", r, mul_exp(-32768, -32768));
        rd(4'd5, s);
        check("R2 status after multiply", s, 0);
    endtask

    task automatic do_div(input int a, input int b, input string tag);
        logic [39:0] r;
        int n;
        wr(4'd0, 8'h01);
        load_ab(a, b);
        wait_div(n);
        check({tag, " busy cycles (R6)"}, n, 16);
        rd_res(r);
        check(tag, r, div_exp(a, b));
    endtask

    task automatic t_div;
        logic [39:0] r;
        do_div(100, 7, "R5 positive divide");
        do_div(-100, 7, "R5 negative dividend");
        do_div(-7, 2, "R5 truncation toward zero");
        do_div(32767, 65535, "R5 unsigned large divisor");
        do_div(-5, 32768, "R5 divisor top bit unsigned");
        do_div(-32768, 3, "R5 most negative dividend");
        do_div(1234, 0, "R7 divide by zero");
        wr(4'd0, 8'h00);
        wr(4'd4, 8'h01);
        rd_res(r);
        check("R6 operands cleared by divide", r, 0);
    endtask

    task automatic t_busy_ignore;
        logic [39:0] r;
        int n;
        wr(4'd0, 8'h01);
        load_ab(50, 5);
        wr(4'd1, 8'h33);
        wr(4'd0, 8'h02);
        wait_div(n);
        rd_res(r);
        check("R8 mode write ignored while busy", r, div_exp(50, 5));
        wr(4'd3, 8'h01);
        wr(4'd4, 8'h00);
        wait_div(n);
        rd_res(r);
        check("R8 operand write ignored while busy", r, 0);
    endtask

    task automatic t_ctrl_clear;
        logic [39:0] r;
        wr(4'd0, 8'h00);
        load_ab(77, 3);
        wr(4'd0, 8'h01);
        rd_res(r);
        check("R9 mode write without clear bit", r, mul_exp(77, 3));
        wr(4'd0, 8'h02);
        rd_res(r);
        check("R9 mode write clears result", r, 0);
    endtask

    task automatic t_acc;
        logic [39:0] r;
        logic [7:0]  s;
        wr(4'd0, 8'h02);
        load_ab(3, 1000);
        wr(4'd3, 8'h9C);
        wr(4'd4, 8'hFF);
        rd_res(r);
        check("R10 accumulate two products", r, 40'd2700);
        rd(4'd5, s);
        check("R10 no overflow in range", s, 0);
        wr(4'd4, 8'h00);
        rd_res(r);
        check("R10 B cleared after accumulate", r, 40'd2700);
    endtask

    task automatic t_ovf;
        logic [39:0] r;
        logic [7:0]  s;
        wr(4'd0, 8'h02);
        wr(4'd1, 8'h00); wr(4'd2, 8'h80);
        for (int i = 0; i < 1023; i++) begin
            wr(4'd3, 8'h00); wr(4'd4, 8'h80);
        end
        rd_res(r);
        check("R11 just below limit", r, 40'hFF_C000_0000);
        rd(4'd5, s);
        check("R11 no overflow below limit", s, 0);
        wr(4'd3, 8'h00); wr(4'd4, 8'h80);
        rd_res(r);
        check("R11 wraps at limit", r, 0);
        rd(4'd5, s);
        check("R11 overflow at limit", s, 8'h80);
        wr(4'd3, 8'h00); wr(4'd4, 8'h80);
        rd(4'd5, s);
        check("R11 overflow sticky after accumulate", s, 8'h80);
        rd_res(r);
        check("R11 accumulate continues", r, 40'h00_4000_0000);
        wr(4'd0, 8'h00);
        load_ab(2, 2);
        rd(4'd5, s);
        check("R11 overflow sticky after multiply", s, 8'h80);
        wr(4'd0, 8'h03);
        rd(4'd5, s);
        check("R9 clear drops overflow", s, 0);
        load_ab(-1, 1);
        rd_res(r);
        check("R11 underflow wraps (R2 mode 3 accumulates)", r, 40'hFF_FFFF_FFFF);
        rd(4'd5, s);
        check("R11 underflow sets overflow", s, 8'h80);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mul();
        t_div();
        t_busy_ignore();
        t_ctrl_clear();
        t_acc();
        t_ovf();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule